// File: doc/BRIEF.md
# Event Counter Bank with Global Start/Stop and Sticky Overflow Status

This block holds a bank of event counters. Each counter adds one on every clock cycle in which its bit in a shared control word is set and its one-bit event line is high. Software writes the control word once to start or stop any subset of the counters. Counters in that subset that watch the same event therefore hold identical values.

Software loads each counter with a value whose top bit is set. When the counter passes its all-ones value it wraps to zero and marks a sticky bit in a status word that software can only read. The only way to remove these marks is to write ones to a separate acknowledge word. A registered level interrupt request is high while any mark is present. No unmask step is needed after an acknowledge.

All registers sit behind one flat read/write port. Word addresses 0 to N-1 hold the counters, 8 holds the control word, 9 holds the status word and 10 holds the acknowledge word. Reads return data in the same cycle. Writes take effect at the next clock edge. The reset input is asynchronous and active-low, and the block releases it internally on a clock edge after a two-stage synchroniser.

Top module: `perf_ctr_bank`

## Requirements
- R1: Counter i gains exactly one at each clock edge where control bit i is set and event_in[i] is high. At every other edge it keeps its value.
- R2: A write to address 8 loads wdata[N-1:0] into the control word in one cycle. Every selected counter starts or stops counting at the same edge. A read of address 8 returns the control word.
- R3: When counter i increments from all ones it wraps to zero, and at that same edge status bit i (status word at address 9, bit position i) becomes 1 and stays 1.
- R4: The status word is read-only. A write to address 9 leaves it unchanged.
- R5: Writing address 10 clears each status bit i whose wdata bit i is 1. Bits written 0 and wdata bits at position N or above have no effect. Address 10 reads as zero.
- R6: If an overflow of counter i and a clear of status bit i occur at the same edge, the bit ends up set.
- R7: irq is high one cycle after any status bit is set. It goes low one cycle after the last set bit is cleared. A later overflow raises it again with no other action.
- R8: A write to address i (i < N) loads wdata[W-1:0] into counter i and takes priority over an increment at the same edge. A read of address i returns the counter zero-extended.
- R9: Reset clears every counter, the control word, the status word and irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | N | One event line per counter |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| irq | output | 1 | Level interrupt request, registered |

## Verification
A counter that is wrong internally shows at its read address in the very next cycle. That makes off-by-one stepping, a missed write priority and a lost stop easy to see after a known number of enabled edges. A status bit that is dropped, set twice or cleared by the wrong word appears at address 9 one cycle after the edge involved, and in irq one cycle later still. For that reason the bench checks status and irq on consecutive cycles around each wrap and each acknowledge.

// File: rtl/perf_bank_pkg.sv
package perf_bank_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 64;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_ACK = 4'd10;
endpackage

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         inc, cnt_we;

  always_comb begin
    inc    = en && evt && !ld;
    cnt_we = ld || inc;
    cnt_d  = ld ? ld_val : cnt_q + 1'b1;
    ovf    = inc && (&cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !(en && evt)) |=> cnt_q == $past(cnt_q));
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && en && evt) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == '0);
endmodule

// File: rtl/perf_ovf_status.sv
module perf_ovf_status #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ovf,
  input  logic         ack_we,
  input  logic [N-1:0] ack_bits,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] stat_q, stat_d, ack_m;
  logic         stat_we;
  logic         irq_q;

  always_comb begin
    ack_m   = ack_we ? ack_bits : '0;
    stat_d  = (stat_q & ~ack_m) | ovf;
    stat_we = ack_we || (ovf != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_we) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |stat_q;
  end

  assign status = stat_q;
  assign irq    = irq_q;

  assert_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> (stat_q & $past(ovf)) == $past(ovf));
  assert_clear_only_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(stat_q) & ~stat_q & ~$past(ack_m)) == '0);
  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(stat_q) != '0);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == '0) |=> !irq_q);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_bank_pkg::*;
#(
  parameter int N = 6,
  parameter int W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      event_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int PAD_W = DATA_W - W;

  logic [1:0]   rst_sync_q;
  logic         rst_core_n;
  logic [N-1:0] ctl_q, ctl_d;
  logic         ctl_we;
  logic [N-1:0] ctr_ld, ovf, status;
  logic         ack_we;
  logic [W-1:0] cnt_q [N];
  logic         unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign unused_wdata = ^reg_wdata[DATA_W-1:W];

  always_comb begin
    ctl_we = reg_wr && (reg_addr == ADDR_CTL);
    ctl_d  = reg_wdata[N-1:0];
    ack_we = reg_wr && (reg_addr == ADDR_ACK);
    for (int i = 0; i < N; i++) ctr_ld[i] = reg_wr && (reg_addr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  ctl_q <= '0;
    else if (ctl_we)  ctl_q <= ctl_d;
  end

  for (genvar g = 0; g < N; g++) begin : g_ctr
    perf_ctr_slice #(.W(W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .en     (ctl_q[g]),
      .evt    (event_in[g]),
      .ld     (ctr_ld[g]),
      .ld_val (reg_wdata[W-1:0]),
      .cnt    (cnt_q[g]),
      .ovf    (ovf[g])
    );
  end

  perf_ovf_status #(.N(N)) u_status (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ovf      (ovf),
    .ack_we   (ack_we),
    .ack_bits (reg_wdata[N-1:0]),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTL)       reg_rdata[N-1:0] = ctl_q;
    else if (reg_addr == ADDR_STAT) reg_rdata[N-1:0] = status;
    else begin
      for (int i = 0; i < N; i++)
        if (reg_addr == ADDR_W'(i)) reg_rdata = {{PAD_W{1'b0}}, cnt_q[i]};
    end
  end

  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !ctl_we |=> $stable(ctl_q));
  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    ctl_we |=> ctl_q == $past(reg_wdata[N-1:0]));
endmodule

// File: tb/perf_ctr_bank_test.sv
`timescale 1ns/1ps
module perf_ctr_bank_test;
  localparam int N = 6;
  localparam int W = 48;
  localparam logic [3:0] A_CTL = 4'd8, A_STAT = 4'd9, A_ACK = 4'd10;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  localparam int NV = 5;
  localparam logic [47:0] V_PRE [NV] = '{48'd0, 48'd100, 48'd7, 48'hFFFF_FFFF_FFFE, 48'h8000_0000_0000};
  localparam logic        V_EN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic        V_EV  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int          V_CYC [NV] = '{5, 5, 4, 3, 2};
  localparam logic [47:0] V_EXP [NV] = '{48'd5, 48'd100, 48'd7, 48'd1, 48'h8000_0000_0002};
  localparam logic        V_OVF [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] event_in;
  logic [3:0]  reg_addr;
  logic        reg_wr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_ctr_bank #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .event_in(event_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; event_in = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    rd(4'd0, v); check("R9 counter0", v, 64'd0);
    rd(A_CTL, v); check("R9 control", v, 64'd0);
    rd(A_STAT, v); check("R9 status", v, 64'd0);
    check("R9 irq", {63'd0, irq}, 64'd0);

    // Vector table on counter 0 (R1, R3)
    for (int k = 0; k < NV; k++) begin
      wr(A_ACK, 64'h3F); wr(A_CTL, 64'd0);
      wr(4'd0, {16'd0, V_PRE[k]});
      event_in[0] = V_EV[k];
      wr(A_CTL, {63'd0, V_EN[k]});
      repeat (V_CYC[k] - 1) @(negedge clk);
      wr(A_CTL, 64'd0);
      event_in = '0;
      rd(4'd0, v); check("R1/R3 vector count", v, {16'd0, V_EXP[k]});
      rd(A_STAT, v); check("R3 vector status bit", {63'd0, v[0]}, {63'd0, V_OVF[k]});
    end
    wr(A_ACK, 64'h3F);

    // R2 one write starts all counters together
    for (int i = 0; i < N; i++) wr(4'(i), 64'd0);
    event_in = '1;
    wr(A_CTL, 64'h3F);
    repeat (9) @(negedge clk);
    wr(A_CTL, 64'd0);
    for (int i = 0; i < N; i++) begin rd(4'(i), v); check("R2 all counters equal", v, 64'd10); end
    for (int i = 0; i < N; i++) wr(4'(i), 64'd0);
    wr(A_CTL, 64'h05);
    rd(A_CTL, v); check("R2 control readback", v, 64'h05);
    repeat (3) @(negedge clk);
    wr(A_CTL, 64'd0);
    for (int i = 0; i < N; i++) begin
      rd(4'(i), v); check("R2 subset", v, (i == 0 || i == 2) ? 64'd4 : 64'd0);
    end
    event_in = '0;

    // R4 / R5 status read-only and acknowledge
    wr(4'd0, {16'd0, ONES}); wr(4'd2, {16'd0, ONES});
    event_in = 6'b000101;
    wr(A_CTL, 64'h05);
    @(negedge clk);
    wr(A_CTL, 64'd0);
    event_in = '0;
    rd(A_STAT, v); check("R3 two overflows", v, 64'h05);
    wr(A_STAT, 64'd0);
    rd(A_STAT, v); check("R4 write zero ignored", v, 64'h05);
    wr(A_STAT, '1);
    rd(A_STAT, v); check("R4 write ones ignored", v, 64'h05);
    wr(A_ACK, 64'hFFFF_FFFF_FFFF_FFC0);
    rd(A_STAT, v); check("R5 upper ack bits ignored", v, 64'h05);
    rd(A_ACK, v); check("R5 ack reads zero", v, 64'd0);
    wr(A_ACK, 64'h01);
    rd(A_STAT, v); check("R5 clear one bit", v, 64'h04);
    wr(A_ACK, 64'h04);
    rd(A_STAT, v); check("R5 clear last bit", v, 64'd0);
    @(negedge clk);

    // R7 irq timing
    wr(4'd0, {16'd0, ONES});
    event_in[0] = 1'b1;
    wr(A_CTL, 64'h01);
    @(negedge clk);
    rd(A_STAT, v); check("R3 wrap sets bit", v, 64'h01);
    check("R7 irq one cycle late", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R7 irq high", {63'd0, irq}, 64'd1);
    wr(A_CTL, 64'd0);
    event_in = '0;
    wr(A_ACK, 64'h01);
    check("R7 irq still high after clear", {63'd0, irq}, 64'd1);
    @(negedge clk);
    check("R7 irq low", {63'd0, irq}, 64'd0);
    wr(4'd0, {16'd0, ONES});
    event_in[0] = 1'b1;
    wr(A_CTL, 64'h01);
    @(negedge clk); @(negedge clk);
    check("R7 irq reasserts", {63'd0, irq}, 64'd1);
    wr(A_CTL, 64'd0);
    event_in = '0;
    wr(A_ACK, 64'h3F);
    @(negedge clk);

    // R6 overflow and clear on the same edge
    wr(4'd1, {16'd0, ONES});
    event_in[1] = 1'b1;
    wr(A_CTL, 64'h02);
    wr(A_ACK, 64'h02);
    rd(A_STAT, v); check("R6 overflow wins", v, 64'h02);
    wr(A_CTL, 64'd0);
    event_in = '0;
    wr(A_ACK, 64'h3F);

    // R8 write beats increment, upper bits dropped
    wr(4'd3, 64'd0);
    event_in[3] = 1'b1;
    wr(A_CTL, 64'h08);
    @(negedge clk);
    wr(4'd3, 64'd1234);
    rd(4'd3, v); check("R8 write wins over increment", v, 64'd1234);
    wr(A_CTL, 64'd0);
    event_in = '0;
    wr(4'd4, 64'hABCD_0000_0000_0005);
    rd(4'd4, v); check("R8 low W bits loaded", v, 64'd5);

    // R9 asynchronous reset mid-run
    wr(4'd5, {16'd0, ONES});
    event_in[5] = 1'b1;
    wr(A_CTL, 64'h20);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    rd(4'd4, v); check("R9 counter cleared", v, 64'd0);
    rd(A_CTL, v); check("R9 control cleared", v, 64'd0);
    rd(A_STAT, v); check("R9 status cleared", v, 64'd0);
    check("R9 irq cleared", {63'd0, irq}, 64'd0);
    event_in = '0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule